// File: doc/BRIEF.md
# Maskable Event Interrupt Controller

This block gathers a small set of asynchronous events into an 8-bit pending register, gates them with an 8-bit enable mask, and drives one active-low interrupt line toward the host. Two kinds of event exist. The first is a once-per-second tick, counted from a clock-enable strobe. The second is a reply from a peripheral bus. A bus reply carries its own payload bytes, and a second flag marks replies that came from autonomous polling rather than from an explicit request.

The host talks to the block through already-framed commands: an opcode, an argument count and one argument byte. A mask command replaces the enable mask. An acknowledge command returns the pending state as a byte stream and clears what it returned. When a bus reply is waiting, the acknowledge returns only the two bus flags followed by the stored reply payload, and leaves every other pending event in place. With no bus reply waiting, it returns the whole pending register as one byte and clears all of it.

Top module: `evt_irq_top`

## Requirements
- R1: After reset the pending register is zero, the mask is 0x90 (bus-reply bit 4 and tick bit 7 enabled), `irq_n` is high and no response is streaming.
- R2: `irq_n` is low exactly when some pending bit is also set in the mask, and it follows the registered state in the same cycle as any change to the pending bits or the mask.
- R3: Every `TICKS_PER_SEC`-th cycle in which `tick_en` is high sets pending bit 7. The period counter wraps exactly at that count, so cycles with `tick_en` low add nothing and no drift builds up.
- R4: An accepted `rpl_post` sets pending bit 4, sets pending bit 2 to the value of `rpl_auto`, and stores `rpl_len` bytes of `rpl_data`, with byte k at bits [8k+7:8k]. A length above `RPL_MAX` is saturated to `RPL_MAX`.
- R5: A post with `rpl_auto` high is dropped when bit 4 is already pending. A post with `rpl_auto` low is always accepted and replaces any stored reply.
- R6: Acknowledge (op 1, argc 0) with bit 4 pending streams a first byte holding only bits 4 and 2 of the pending register, then the stored reply bytes. The stream length is the reply length plus 1, and only bits 4 and 2 and the stored length are cleared.
- R7: Acknowledge with bit 4 clear streams one byte equal to the whole pending register and clears the register.
- R8: Set-mask (op 2, argc 1) loads `cmd_arg` into the mask.
- R9: An acknowledge with argc other than 0, or a set-mask with argc other than 1, changes no state and starts no stream.
- R10: An event that sets a bit in the same cycle as an acknowledge clears it leaves that bit pending.
- R11: Any command presented while a response is streaming is ignored.
- R12: A response starts in the cycle after the acknowledge and delivers one byte per cycle with `rsp_valid` high. `rsp_last` is high only on the final byte, `rsp_len` gives the total byte count, and `rsp_valid` drops in the cycle after the final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase clock enable, one count per high cycle |
| rpl_post | input | 1 | Bus reply arrival strobe |
| rpl_auto | input | 1 | Reply comes from autonomous polling |
| rpl_len | input | $clog2(RPL_MAX+1) | Reply payload length in bytes |
| rpl_data | input | 8*RPL_MAX | Reply payload, byte k at bits [8k+7:8k] |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Opcode: 1 acknowledge, 2 set mask, others no-op |
| cmd_argc | input | ARGC_W | Number of argument bytes supplied |
| cmd_arg | input | 8 | First argument byte |
| irq_n | output | 1 | Active-low interrupt request |
| rsp_valid | output | 1 | Response byte present |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Final byte of the response |
| rsp_len | output | $clog2(RPL_MAX+2) | Total bytes in the current response |

## Verification
The checker watches the cycle-level rules on every clock. It checks that a tick comes only from an enabled cycle and always lands in the pending register, that malformed or busy-time mask commands leave the mask alone, that a dropped autopoll reply keeps the stored payload, that a masked-off state keeps `irq_n` high, and that a stream runs without gaps and ends right after its last byte. Only the directed scenarios can show the content of the acknowledge stream: which flag byte comes first, payload order, length saturation, the partial clear that keeps a tick pending behind a bus reply, the exact tick period, and the set-beats-clear collision.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int EV_W     = 8;
  localparam int BIT_AUTO = 2;
  localparam int BIT_BUS  = 4;
  localparam int BIT_TICK = 7;

  localparam logic [EV_W-1:0] BUS_FLAGS = EV_W'((1 << BIT_BUS) | (1 << BIT_AUTO));
  localparam logic [EV_W-1:0] MASK_RST  = EV_W'((1 << BIT_BUS) | (1 << BIT_TICK));

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ACK  = 2'd1,
    OP_MASK = 2'd2,
    OP_RSVD = 2'd3
  } evt_op_e;
endpackage

// File: rtl/evt_tick_gen.sv
module evt_tick_gen #(
  parameter int TICKS_PER_SEC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  output logic tick_o
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    tick_o = 1'b0;
    if (tick_en) begin
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        tick_o = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/evt_core.sv
module evt_core
  import evt_irq_pkg::*;
#(
  parameter int RPL_MAX = 8,
  parameter int LW      = $clog2(RPL_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   rpl_post,
  input  logic                   rpl_auto,
  input  logic [LW-1:0]          rpl_len,
  input  logic [8*RPL_MAX-1:0]   rpl_data,
  input  logic                   ack_go,
  input  logic                   mask_wr,
  input  logic [EV_W-1:0]        mask_val,
  output logic [EV_W-1:0]        pend_q,
  output logic [EV_W-1:0]        mask_q,
  output logic [8*RPL_MAX-1:0]   rbuf_q,
  output logic [LW-1:0]          rlen_q,
  output logic                   irq_n
);
  localparam logic [LW-1:0] LEN_CAP = LW'(RPL_MAX);

  logic [EV_W-1:0] pend_d, set_v, clr_v, mask_d;
  logic [LW-1:0]   rlen_d, take_len;
  logic            rpl_take;

  always_comb begin
    rpl_take = rpl_post && !(rpl_auto && pend_q[BIT_BUS]);
    take_len = (rpl_len > LEN_CAP) ? LEN_CAP : rpl_len;

    set_v = '0;
    if (tick)     set_v[BIT_TICK] = 1'b1;
    if (rpl_take) set_v[BIT_BUS]  = 1'b1;

    clr_v = '0;
    if (ack_go) clr_v = pend_q[BIT_BUS] ? BUS_FLAGS : '1;

    pend_d = (pend_q & ~clr_v) | set_v;
    if (rpl_take) pend_d[BIT_AUTO] = rpl_auto;

    rlen_d = rlen_q;
    if (ack_go && pend_q[BIT_BUS]) rlen_d = '0;
    if (rpl_take) rlen_d = take_len;

    mask_d = mask_wr ? mask_val : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= MASK_RST;
      rlen_q <= '0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
      rlen_q <= rlen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rbuf_q <= '0;
    else if (rpl_take) rbuf_q <= rpl_data;
  end

  assign irq_n = ~|(pend_q & mask_q);
endmodule

// File: rtl/evt_rsp_ser.sv
module evt_rsp_ser #(
  parameter int RPL_MAX = 8,
  parameter int LW      = $clog2(RPL_MAX + 1),
  parameter int SW      = $clog2(RPL_MAX + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 load_bus,
  input  logic [7:0]           head,
  input  logic [8*RPL_MAX-1:0] rbuf,
  input  logic [LW-1:0]        rlen,
  output logic                 rsp_valid,
  output logic [7:0]           rsp_data,
  output logic                 rsp_last,
  output logic [SW-1:0]        rsp_len
);
  localparam int BW = 8 * (RPL_MAX + 1);

  logic [BW-1:0] sbuf_q, sbuf_d;
  logic [SW-1:0] slen_q, slen_d, idx_q, idx_d;
  logic          act_q, act_d, at_end;

  assign at_end = (idx_q == slen_q - SW'(1));

  always_comb begin
    sbuf_d = sbuf_q;
    slen_d = slen_q;
    idx_d  = idx_q;
    act_d  = act_q;
    if (load) begin
      sbuf_d = {rbuf, head};
      slen_d = load_bus ? (SW'(rlen) + SW'(1)) : SW'(1);
      idx_d  = '0;
      act_d  = 1'b1;
    end else if (act_q) begin
      if (at_end) act_d = 1'b0;
      else        idx_d = idx_q + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      slen_q <= '0;
    end else begin
      act_q  <= act_d;
      idx_q  <= idx_d;
      slen_q <= slen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sbuf_q <= '0;
    else if (load) sbuf_q <= sbuf_d;
  end

  assign rsp_valid = act_q;
  assign rsp_data  = sbuf_q[8*idx_q +: 8];
  assign rsp_last  = act_q && at_end;
  assign rsp_len   = slen_q;
endmodule

// File: rtl/evt_irq_top.sv
module evt_irq_top
  import evt_irq_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1000,
  parameter int RPL_MAX       = 8,
  parameter int ARGC_W        = 4,
  localparam int LW           = $clog2(RPL_MAX + 1),
  localparam int SW           = $clog2(RPL_MAX + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 rpl_post,
  input  logic                 rpl_auto,
  input  logic [LW-1:0]        rpl_len,
  input  logic [8*RPL_MAX-1:0] rpl_data,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [ARGC_W-1:0]    cmd_argc,
  input  logic [7:0]           cmd_arg,
  output logic                 irq_n,
  output logic                 rsp_valid,
  output logic [7:0]           rsp_data,
  output logic                 rsp_last,
  output logic [SW-1:0]        rsp_len
);
  logic                 tick_p, cmd_ok, ack_go, mask_wr;
  logic [EV_W-1:0]      pend_q, mask_q, head;
  logic [8*RPL_MAX-1:0] rbuf_q;
  logic [LW-1:0]        rlen_q;

  assign cmd_ok  = cmd_valid && !rsp_valid;
  assign ack_go  = cmd_ok && (cmd_op == OP_ACK)  && (cmd_argc == ARGC_W'(0));
  assign mask_wr = cmd_ok && (cmd_op == OP_MASK) && (cmd_argc == ARGC_W'(1));
  assign head    = pend_q[BIT_BUS] ? (pend_q & BUS_FLAGS) : pend_q;

  evt_tick_gen #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tick_o(tick_p)
  );

  evt_core #(.RPL_MAX(RPL_MAX), .LW(LW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick_p),
    .rpl_post(rpl_post), .rpl_auto(rpl_auto), .rpl_len(rpl_len), .rpl_data(rpl_data),
    .ack_go(ack_go), .mask_wr(mask_wr), .mask_val(cmd_arg),
    .pend_q(pend_q), .mask_q(mask_q), .rbuf_q(rbuf_q), .rlen_q(rlen_q), .irq_n(irq_n)
  );

  evt_rsp_ser #(.RPL_MAX(RPL_MAX), .LW(LW), .SW(SW)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(ack_go), .load_bus(pend_q[BIT_BUS]),
    .head(head), .rbuf(rbuf_q), .rlen(rlen_q),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last), .rsp_len(rsp_len)
  );
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
  import evt_irq_pkg::*;
#(
  parameter int ARGC_W = 4,
  parameter int LW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              tick_p,
  input logic              ack_go,
  input logic [EV_W-1:0]   pend_q,
  input logic [EV_W-1:0]   mask_q,
  input logic [LW-1:0]     rlen_q,
  input logic              rpl_post,
  input logic              rpl_auto,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [ARGC_W-1:0] cmd_argc,
  input logic              irq_n,
  input logic              rsp_valid,
  input logic              rsp_last
);
  assert_tick_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_p |-> tick_en);

  assert_tick_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_p |=> pend_q[BIT_TICK]);

  assert_bad_mask_argc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !rsp_valid && cmd_op == OP_MASK && cmd_argc != ARGC_W'(1))
      |=> $stable(mask_q));

  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && rsp_valid) |=> $stable(mask_q));

  assert_auto_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rpl_post && rpl_auto && pend_q[BIT_BUS] && !ack_go)
      |=> (pend_q[BIT_BUS] && $stable(rlen_q)));

  assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> irq_n);

  assert_stream_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_last) |=> !rsp_valid);

  assert_stream_gapless_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_last) |=> rsp_valid);
endmodule

bind evt_irq_top evt_irq_chk #(.ARGC_W(ARGC_W), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tick_p(tick_p), .ack_go(ack_go),
  .pend_q(pend_q), .mask_q(mask_q), .rlen_q(rlen_q),
  .rpl_post(rpl_post), .rpl_auto(rpl_auto),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_argc(cmd_argc),
  .irq_n(irq_n), .rsp_valid(rsp_valid), .rsp_last(rsp_last)
);

// File: tb/evt_irq_top_tb.sv
module evt_irq_top_tb;
  localparam int TK = 5;
  localparam int RM = 8;
  localparam int LW = $clog2(RM + 1);
  localparam int SW = $clog2(RM + 2);

  logic            clk, rst_n, tick_en, rpl_post, rpl_auto, cmd_valid;
  logic [LW-1:0]   rpl_len;
  logic [8*RM-1:0] rpl_data;
  logic [1:0]      cmd_op;
  logic [3:0]      cmd_argc;
  logic [7:0]      cmd_arg, rsp_data;
  logic            irq_n, rsp_valid, rsp_last;
  logic [SW-1:0]   rsp_len;

  int nchk = 0, nfail = 0, nb;
  logic [7:0] got [16];
  logic       lastf [16];
  int         glen;

  evt_irq_top #(.TICKS_PER_SEC(TK), .RPL_MAX(RM), .ARGC_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rpl_post(rpl_post), .rpl_auto(rpl_auto),
    .rpl_len(rpl_len), .rpl_data(rpl_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_argc(cmd_argc), .cmd_arg(cmd_arg), .irq_n(irq_n), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_last(rsp_last), .rsp_len(rsp_len)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic post(input logic au, input int len, input logic [8*RM-1:0] d);
    rpl_post = 1'b1; rpl_auto = au; rpl_len = LW'(len); rpl_data = d;
    @(negedge clk);
    rpl_post = 1'b0; rpl_auto = 1'b0;
  endtask

  task automatic run_cmd(input logic [1:0] op, input int argc, input logic [7:0] arg,
                         input logic with_tick);
    cmd_valid = 1'b1; cmd_op = op; cmd_argc = 4'(argc); cmd_arg = arg; tick_en = with_tick;
    @(negedge clk);
    cmd_valid = 1'b0; tick_en = 1'b0;
    nb = 0;
    glen = int'(rsp_len);
    while (rsp_valid && nb < 16) begin
      got[nb] = rsp_data; lastf[nb] = rsp_last; nb++;
      @(negedge clk);
    end
  endtask

  task automatic ack_expect(input string r, input int n, input logic [7:0] b0,
                            input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3);
    logic [7:0] e [4];
    e[0] = b0; e[1] = b1; e[2] = b2; e[3] = b3;
    run_cmd(2'd1, 0, 8'h00, 1'b0);
    chk({r, " count"}, nb, n);
    if (nb == n && n > 0) begin
      chk({r, " R12 rsp_len"}, glen, n);
      for (int i = 0; i < n && i < 4; i++) chk({r, " byte"}, got[i], e[i]);
      for (int i = 0; i < n; i++) chk({r, " R12 last flag"}, lastf[i], (i == n - 1));
    end
  endtask

  task automatic t_reset;
    chk("R1 irq_n idle", irq_n, 1);
    chk("R1 no stream", rsp_valid, 0);
    ack_expect("R1 R7 empty pending", 1, 8'h00, 0, 0, 0);
    post(1'b0, 0, '0);
    chk("R1 R2 bus bit enabled at reset", irq_n, 0);
    ack_expect("R6 zero-length reply", 1, 8'h10, 0, 0, 0);
    chk("R2 released after ack", irq_n, 1);
  endtask

  task automatic t_tick;
    pulse_ticks(TK - 1);
    chk("R3 no tick before period", irq_n, 1);
    repeat (3) @(negedge clk);
    chk("R3 idle cycles do not count", irq_n, 1);
    pulse_ticks(1);
    chk("R3 tick at period R1 tick enabled", irq_n, 0);
    ack_expect("R7 tick readout", 1, 8'h80, 0, 0, 0);
    chk("R7 cleared", irq_n, 1);
  endtask

  task automatic t_reply;
    post(1'b0, 3, 64'h0000_0000_00CC_BBAA);
    pulse_ticks(TK);
    ack_expect("R4 R6 reply readout", 4, 8'h10, 8'hAA, 8'hBB, 8'hCC);
    chk("R6 tick kept pending", irq_n, 0);
    ack_expect("R6 R7 tick after reply", 1, 8'h80, 0, 0, 0);
    post(1'b0, 12, 64'h0807_0605_0403_0201);
    ack_expect("R4 length saturates", RM + 1, 8'h10, 8'h01, 8'h02, 8'h03);
    chk("R4 last byte of saturated reply", got[RM], 8'h08);
  endtask

  task automatic t_auto;
    post(1'b1, 1, 64'h11);
    ack_expect("R4 autopoll flag", 2, 8'h14, 8'h11, 0, 0);
    post(1'b1, 1, 64'h22);
    post(1'b1, 1, 64'h33);
    ack_expect("R5 second autopoll dropped", 2, 8'h14, 8'h22, 0, 0);
    post(1'b1, 1, 64'h44);
    post(1'b0, 2, 64'h6655);
    ack_expect("R5 explicit reply replaces", 3, 8'h10, 8'h55, 8'h66, 0);
    chk("R5 all cleared", irq_n, 1);
  endtask

  task automatic t_busy;
    post(1'b0, 3, 64'h0030_2010);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_argc = 4'd0; cmd_arg = 8'h00;
    @(negedge clk);
    chk("R12 stream starts next cycle", rsp_valid, 1);
    cmd_op = 2'd2; cmd_argc = 4'd1; cmd_arg = 8'h00;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (rsp_valid) @(negedge clk);
    pulse_ticks(TK);
    chk("R11 mask write ignored while streaming", irq_n, 0);
    ack_expect("R11 R7 tick only", 1, 8'h80, 0, 0, 0);
  endtask

  task automatic t_collide;
    pulse_ticks(TK);
    pulse_ticks(TK - 1);
    run_cmd(2'd1, 0, 8'h00, 1'b1);
    chk("R10 readout count", nb, 1);
    chk("R10 readout value", got[0], 8'h80);
    chk("R10 new tick survives clear", irq_n, 0);
    ack_expect("R10 tick still pending", 1, 8'h80, 0, 0, 0);
  endtask

  task automatic t_mask;
    pulse_ticks(TK);
    chk("R2 tick asserts", irq_n, 0);
    run_cmd(2'd2, 2, 8'h00, 1'b0);
    chk("R9 no stream for mask", nb, 0);
    chk("R9 mask argc 2 ignored", irq_n, 0);
    run_cmd(2'd2, 1, 8'h00, 1'b0);
    chk("R8 R2 mask cleared", irq_n, 1);
    run_cmd(2'd2, 1, 8'h80, 1'b0);
    chk("R8 R2 mask tick only", irq_n, 0);
    run_cmd(2'd1, 1, 8'h00, 1'b0);
    chk("R9 ack argc 1 no stream", nb, 0);
    chk("R9 ack argc 1 keeps pending", irq_n, 0);
    run_cmd(2'd3, 0, 8'h00, 1'b0);
    chk("R9 reserved op no stream", nb, 0);
    post(1'b0, 1, 64'h5A);
    ack_expect("R8 bus bit masked but readable", 2, 8'h10, 8'h5A, 0, 0);
    chk("R8 masked bus reply no irq effect", irq_n, 0);
    ack_expect("R7 final tick", 1, 8'h80, 0, 0, 0);
    chk("R2 released", irq_n, 1);
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; rpl_post = 1'b0; rpl_auto = 1'b0; rpl_len = '0;
    rpl_data = '0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_argc = 4'd0; cmd_arg = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tick();
    t_reply();
    t_auto();
    t_busy();
    t_collide();
    t_mask();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired R12 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule